// File: doc/BRIEF.md
# Coprocessor Bus Region Decoder

This block stands between the 32-bit bus of an embedded coprocessor and its byte-wide memories: program ROM, data ROM, work RAM and a small mailbox peripheral. Each CPU request arrives on a valid/ready channel. The block decodes the region from the top address nibble and masks the address down to the size of that region. It then issues the access as byte operations on a single memory port, one operation per cycle. A byte access becomes one operation. A word access becomes four operations to the word-aligned address plus 0, 1, 2 and 3, split or assembled little-endian.

Reads from regions with nothing behind them return zero. Writes to ROM or to unmapped regions never reach the memory port. After the last byte the block presents one response on a valid/ready channel. The response carries the assembled read data and a flag that marks an instruction prefetch. A free-running counter advances by one for every accepted bus access and by one for every cycle the CPU reports as idle.

Back-pressure rules: `req_ready` is high only while no request is in flight and no response is waiting. A request moves on the cycle that `req_valid` and `req_ready` are both high. `rsp_valid` and `rsp_rdata` stay steady until the cycle that `rsp_ready` is high. The memory port has no back-pressure: a read presented in one cycle returns its byte on `mem_rdata` in the next cycle.

Top module: `cop_bus_decoder`

## Requirements
- R1: Addresses with bits 31:28 equal to 0x0 go to program ROM. `mem_sel` is 0 and `mem_addr` is the address masked with 0x1FFFF.
- R2: Nibble 0xA goes to data ROM (`mem_sel` 1, mask 0x7FFF). Nibble 0xE goes to work RAM (`mem_sel` 2, mask 0x3FFF).
- R3: Nibble 0x4 goes to the mailbox peripheral (`mem_sel` 3). `mem_addr` is address bits 5:0, zero-extended.
- R4: Every other nibble is unmapped. Such an access produces no `mem_valid` cycle, and its read data is zero.
- R5: A word read issues four read operations, one per cycle, to the aligned address plus 0, 1, 2, 3 in that order. The byte at offset 0 lands in `rsp_rdata[7:0]` and the byte at offset 3 lands in bits 31:24.
- R6: A word write issues four write operations to the aligned address plus 0 to 3. `wdata[8k+7:8k]` goes to offset k.
- R7: Writes to program ROM, data ROM or unmapped regions raise no `mem_valid` cycle. Only work RAM and the peripheral take writes.
- R8: `cycle_count` resets to 0. It rises by one for each accepted request and by one for each cycle with `idle_tick` high, so by two when both happen in the same cycle.
- R9: `req_ready` is high only when idle. The response appears N+1 clock edges after the accepting edge, where N is the number of byte operations. It holds steady until `rsp_ready` and then drops.
- R10: `rsp_fetch` equals the request's `req_fetch` for word accesses and is 0 for byte accesses.
- R11: A byte access issues one operation at the unaligned address itself, uses `req_wdata[7:0]` for writes, and returns the byte zero-extended in `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction prefetch |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | CPU takes the response |
| rsp_rdata | output | 32 | Assembled read data (zero for writes) |
| rsp_fetch | output | 1 | Response belongs to a word prefetch |
| idle_tick | input | 1 | CPU spent this cycle idle |
| cycle_count | output | 32 | Access and idle cycle count |
| mem_valid | output | 1 | Byte operation on the memory port |
| mem_we | output | 1 | Operation is a write |
| mem_sel | output | 2 | 0 program ROM, 1 data ROM, 2 work RAM, 3 peripheral |
| mem_addr | output | 17 | Masked byte offset within the region |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after the read operation |

## Verification
The bench sweeps all sixteen address nibbles, each at a low, a middle and a near-top offset, with byte and word accesses in both directions. A wrong mask would show up as a stray high bit on `mem_addr`. A decoder that let ROM writes through, or that touched the memory for an unmapped nibble, would log an operation the bench does not expect. An unaligned word near the top of a region catches lane order and alignment mistakes: reversed byte assembly, or an address that is not cleared to the aligned base. Held responses, and idle ticks that land on the same cycle as an accepted request, expose a response that changes before it is taken and a counter that adds only one when both events fall in one cycle.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    SEL_PROG = 2'd0,
    SEL_DATA = 2'd1,
    SEL_WRAM = 2'd2,
    SEL_PERI = 2'd3
  } sel_e;

  typedef struct packed {
    logic mapped;
    logic writable;
    sel_e sel;
  } region_t;

endpackage

// File: rtl/cbd_region_decode.sv
module cbd_region_decode
  import cbd_pkg::*;
#(
  parameter int PROG_AW = 17,
  parameter int DATA_AW = 15,
  parameter int WRAM_AW = 14,
  parameter int PERI_AW = 6,
  parameter int MEM_AW  = 17
) (
  input  logic [31:0]       addr,
  output region_t           region,
  output logic [MEM_AW-1:0] offset
);

  logic unused_addr;
  assign unused_addr = ^addr;

  always_comb begin
    region = '{mapped: 1'b0, writable: 1'b0, sel: SEL_PROG};
    offset = '0;
    unique case (addr[31:28])
      4'h0: begin
        region = '{mapped: 1'b1, writable: 1'b0, sel: SEL_PROG};
        offset[PROG_AW-1:0] = addr[PROG_AW-1:0];
      end
      4'hA: begin
        region = '{mapped: 1'b1, writable: 1'b0, sel: SEL_DATA};
        offset[DATA_AW-1:0] = addr[DATA_AW-1:0];
      end
      4'hE: begin
        region = '{mapped: 1'b1, writable: 1'b1, sel: SEL_WRAM};
        offset[WRAM_AW-1:0] = addr[WRAM_AW-1:0];
      end
      4'h4: begin
        region = '{mapped: 1'b1, writable: 1'b1, sel: SEL_PERI};
        offset[PERI_AW-1:0] = addr[PERI_AW-1:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cbd_cycle_counter.sv
module cbd_cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_fire,
  input  logic             idle_tick,
  output logic [CNT_W-1:0] count
);

  logic [1:0] step;
  assign step = {1'b0, access_fire} + {1'b0, idle_tick};

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(step);
  end

  assert_count_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_fire && !idle_tick) |=> $stable(count));

endmodule

// File: rtl/cbd_lane_seq.sv
module cbd_lane_seq
  import cbd_pkg::*;
#(
  parameter int PROG_AW = 17,
  parameter int DATA_AW = 15,
  parameter int WRAM_AW = 14,
  parameter int PERI_AW = 6,
  parameter int MEM_AW  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_fetch,
  output logic              accept,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [1:0]        mem_sel,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN, ST_RESP} state_e;

  state_e      state_q;
  logic [31:0] addr_q, wdata_q, data_q;
  logic        word_q, write_q, fetch_q;
  logic [1:0]  lane_q, rd_lane_q;
  logic        rd_pend_q, rd_map_q;
  logic [31:0] lane_addr;
  region_t     region;
  logic        last_lane;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lane_addr = word_q ? {addr_q[31:2], lane_q} : addr_q;
  assign last_lane = word_q ? (lane_q == 2'd3) : 1'b1;

  cbd_region_decode #(
    .PROG_AW(PROG_AW), .DATA_AW(DATA_AW), .WRAM_AW(WRAM_AW),
    .PERI_AW(PERI_AW), .MEM_AW(MEM_AW)
  ) u_decode (
    .addr  (lane_addr),
    .region(region),
    .offset(mem_addr)
  );

  assign mem_valid = (state_q == ST_ISSUE) && region.mapped && (!write_q || region.writable);
  assign mem_we    = write_q;
  assign mem_sel   = region.sel;
  assign mem_wdata = wdata_q[{lane_q, 3'b000} +: 8];

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = data_q;
  assign rsp_fetch = fetch_q && word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      data_q    <= '0;
      word_q    <= 1'b0;
      write_q   <= 1'b0;
      fetch_q   <= 1'b0;
      lane_q    <= '0;
      rd_lane_q <= '0;
      rd_pend_q <= 1'b0;
      rd_map_q  <= 1'b0;
    end else begin
      rd_pend_q <= (state_q == ST_ISSUE) && !write_q;
      rd_lane_q <= lane_q;
      rd_map_q  <= region.mapped;
      if (rd_pend_q) data_q[{rd_lane_q, 3'b000} +: 8] <= rd_map_q ? mem_rdata : 8'h00;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          word_q  <= req_word;
          write_q <= req_write;
          fetch_q <= req_fetch;
          lane_q  <= '0;
          data_q  <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          lane_q <= lane_q + 2'd1;
          if (last_lane) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_RESP;
        ST_RESP:  if (rsp_ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_ready_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_fetch)));

  assert_rom_write_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_sel == SEL_WRAM || mem_sel == SEL_PERI));

  assert_byte_zext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !word_q) |-> (rsp_rdata[31:8] == 24'h0));

  assert_fetch_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fetch) |-> word_q);

endmodule

// File: rtl/cop_bus_decoder.sv
module cop_bus_decoder #(
  parameter int PROG_AW = 17,
  parameter int DATA_AW = 15,
  parameter int WRAM_AW = 14,
  parameter int PERI_AW = 6,
  parameter int CNT_W   = 32,
  localparam int MAX_RD = (PROG_AW > DATA_AW) ? PROG_AW : DATA_AW,
  localparam int MAX_WP = (WRAM_AW > PERI_AW) ? WRAM_AW : PERI_AW,
  localparam int MEM_AW = (MAX_RD > MAX_WP) ? MAX_RD : MAX_WP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_fetch,
  input  logic              idle_tick,
  output logic [CNT_W-1:0]  cycle_count,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [1:0]        mem_sel,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  logic accept;

  cbd_lane_seq #(
    .PROG_AW(PROG_AW), .DATA_AW(DATA_AW), .WRAM_AW(WRAM_AW),
    .PERI_AW(PERI_AW), .MEM_AW(MEM_AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_fetch(req_fetch),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_fetch(rsp_fetch), .accept(accept),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  cbd_cycle_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .access_fire(accept), .idle_tick(idle_tick),
    .count(cycle_count)
  );

endmodule

// File: tb/cop_bus_decoder_test.sv
module cop_bus_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_word = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_fetch;
  logic        rsp_ready = 1'b0, idle_tick = 1'b0;
  logic [31:0] rsp_rdata, cycle_count;
  logic        mem_valid, mem_we;
  logic [1:0]  mem_sel;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int tests = 0, fails = 0;
  int exp_count = 0;

  int          nops;
  logic        op_we [4];
  logic [1:0]  op_sel[4];
  logic [16:0] op_adr[4];
  logic [7:0]  op_wd [4];

  always #2.5 clk = ~clk;

  cop_bus_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_word(req_word), .req_write(req_write), .req_fetch(req_fetch),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_fetch(rsp_fetch), .idle_tick(idle_tick), .cycle_count(cycle_count),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [1:0] sel, input logic [16:0] off);
    return 8'((off * 13) + (off >> 8) * 3 + sel * 61 + 5);
  endfunction

  always @(posedge clk) begin
    if (mem_valid && !mem_we) mem_rdata <= mem_byte(mem_sel, mem_addr);
    if (mem_valid && nops < 4) begin
      op_we[nops]  <= mem_we;
      op_sel[nops] <= mem_sel;
      op_adr[nops] <= mem_addr;
      op_wd[nops]  <= mem_wdata;
    end
    if (mem_valid) nops <= nops + 1;
    if (rst_n && idle_tick) exp_count <= exp_count + 1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic region_of(input logic [3:0] nib, output bit mapped, output bit wr,
                           output logic [1:0] sel, output logic [16:0] mask);
    mapped = 1; wr = 0; sel = 0; mask = 0;
    case (nib)
      4'h0: begin sel = 0; mask = 17'h1FFFF; end
      4'hA: begin sel = 1; mask = 17'h07FFF; end
      4'hE: begin sel = 2; mask = 17'h03FFF; wr = 1; end
      4'h4: begin sel = 3; mask = 17'h0003F; wr = 1; end
      default: mapped = 0;
    endcase
  endtask

  task automatic access(input logic [31:0] a, input bit w, input bit wr, input bit f,
                        input logic [31:0] wd, input int hold, input bit tick);
    int n, lat, e;
    bit mp, wok;
    logic [1:0] sel;
    logic [16:0] mask;
    logic [31:0] ea, exp_rd;
    string tg;
    n = w ? 4 : 1;
    region_of(a[31:28], mp, wok, sel, mask);
    tg = (a[31:28] == 4'h0) ? "R1" : (a[31:28] == 4'hA || a[31:28] == 4'hE) ? "R2" :
         (a[31:28] == 4'h4) ? "R3" : "R4";
    @(negedge clk);
    check("R9 ready when idle", req_ready, 1);
    nops = 0;
    req_valid = 1; req_addr = a; req_word = w; req_write = wr; req_fetch = f; req_wdata = wd;
    idle_tick = tick;
    @(posedge clk);
    exp_count++;
    @(negedge clk);
    req_valid = 0; idle_tick = 0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    check("R9 latency", lat, n + 1);
    exp_rd = 0;
    for (int k = 0; k < n; k++) begin
      ea = w ? ({a[31:2], 2'b00} + 32'(k)) : a;
      if (!wr && mp) exp_rd[8*k +: 8] = mem_byte(sel, ea[16:0] & mask);
    end
    check(w ? "R5 word read data" : "R11 byte read data", rsp_rdata, exp_rd);
    check("R10 fetch flag", rsp_fetch, w && f);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R9 response held", {rsp_valid, req_ready, rsp_rdata}, {1'b1, 1'b0, exp_rd});
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check("R9 response dropped", rsp_valid, 0);
    e = (mp && (!wr || wok)) ? n : 0;
    check(wr && !wok ? "R7 dropped write ops" : {tg, " op count"}, nops, e);
    if (nops == e) begin
      for (int k = 0; k < e; k++) begin
        ea = w ? ({a[31:2], 2'b00} + 32'(k)) : a;
        check({tg, w ? " R5 lane addr" : " R11 addr"}, op_adr[k], ea[16:0] & mask);
        check({tg, " sel"}, op_sel[k], sel);
        check("R6 op dir", op_we[k], wr);
        if (wr) check(w ? "R6 lane data" : "R11 write byte", op_wd[k], wd[8*k +: 8]);
      end
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle_tick = 1;
    end
    @(negedge clk); idle_tick = 0;
  endtask

  initial begin
    logic [27:0] offs[3];
    offs[0] = 28'h0000000; offs[1] = 28'h1234567; offs[2] = 28'hFFFFFFD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R9 reset ready", req_ready, 1);
    check("R9 reset rsp_valid", rsp_valid, 0);
    check("R7 reset mem_valid", mem_valid, 0);
    check("R8 reset count", cycle_count, 0);
    for (int nib = 0; nib < 16; nib++) begin
      for (int oi = 0; oi < 3; oi++) begin
        logic [31:0] a;
        a = {4'(nib), offs[oi]};
        access(a, 0, 0, 0, 32'h0, 0, oi == 1);
        access(a, 1, 0, oi != 0, 32'h0, oi, 0);
        access(a, 0, 1, 1, 32'hDEADBE00 | 32'(nib * 17 + oi), 0, 0);
        access(a, 1, 1, 0, 32'hA1B2C3D4 ^ 32'(nib << 8), oi == 2 ? 2 : 0, oi == 2);
        idle_cycles(nib % 3);
      end
      @(negedge clk);
      check("R8 cycle count", cycle_count, exp_count);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule